// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler with Deferral Credit

This block decides when an SDRAM controller should spend a slot on an AUTO REFRESH. A free-running interval timer, advanced by a tick timebase, adds one owed refresh to a pending count each time a nominal refresh period elapses. That period is about 15.6 us, so that 4096 rows are covered every 64 ms. The controller can let the debt grow while it is busy with traffic and then pay it back in a burst. Each accepted refresh grant removes one owed refresh. The count saturates at eight, which is the largest run of back-to-back refreshes the memory accepts.

The request goes high when something is owed and the controller is idle. An urgent flag forces the request high even when the controller is busy. The flag is raised when the debt is full, or when the time since the last refresh nears the limit of eight nominal periods. The block does not drive commands and does not time the refresh-to-command gap; the downstream timing guard handles both. A clear input, used on self-refresh exit, drops the debt to zero and restarts the timers.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `pend_cnt` is 0 and both `ref_req` and `ref_urgent` are low.
- R2: An accepted grant (`ref_grant` high while `pend_cnt` is non-zero) lowers `pend_cnt` by one on the next edge, unless an interval ends on that same edge, in which case the count is unchanged.
- R3: `pend_cnt` never exceeds MAX_PEND (default 8). An interval that ends while the count is at MAX_PEND and no grant is accepted leaves it at MAX_PEND.
- R4: `ref_req` is high exactly when `pend_cnt` is non-zero and either `ctl_busy` is low or `ref_urgent` is high.
- R5: `ref_urgent` is high whenever `pend_cnt` equals MAX_PEND, and in that state `ref_req` is high regardless of `ctl_busy`.
- R6: With a non-zero `pend_cnt`, `ref_urgent` also rises once MAX_PEND × interval − GUARD_TICKS ticks have passed since reset, the last accepted grant or the last clear. No tick is counted after that limit is reached.
- R7: A cycle with `sr_clear` high sets `pend_cnt` to 0 on the next edge and restarts both the interval and deadline counts. It takes priority over ticks and grants.
- R8: A grant while `pend_cnt` is 0 is ignored: the count stays 0 and the deadline count is not restarted.
- R9: Only cycles with `tick` high advance time. While `tick` is low and there is no accepted grant or clear, `pend_cnt` holds.
- R10: The interval length in ticks is INTERVAL_PS / TICK_PERIOD_PS, rounded down (minimum 1). With `tick` held high from reset, `pend_cnt` first becomes 1 on exactly that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one tick per high cycle |
| ctl_busy | input | 1 | Controller is busy with traffic |
| ref_grant | input | 1 | Controller issues the requested refresh this cycle |
| sr_clear | input | 1 | Clear the debt and restart timing (self-refresh exit) |
| ref_req | output | 1 | Refresh wanted now |
| ref_urgent | output | 1 | Refresh must be taken even if busy |
| pend_cnt | output | $clog2(MAX_PEND+1) | Number of refreshes owed |

## Verification
The bench builds the scheduler with a tick period of 4000 ps, an interval of 40000 ps (10 ticks), MAX_PEND of 8 and a guard of 4 ticks, which puts the deadline at 76 ticks. With these values the whole debt range from 0 to 8, saturation, the deadline firing with a count of 7, and burst repayment are reached within a few hundred cycles. A pseudo-random sweep over ticks, busy, grants and clears can then be compared every cycle against an arithmetic model of the count, the elapsed time and the interval phase.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // ticks per nominal refresh interval, rounded down, never below one
  function automatic int unsigned interval_ticks(input longint unsigned interval_ps,
                                                 input longint unsigned tick_ps);
    longint unsigned q;
    q = interval_ps / tick_ps;
    return (q < 1) ? 1 : int'(q);
  endfunction

  // ticks allowed between refreshes before forcing one
  function automatic int unsigned deadline_ticks(input int unsigned per_int,
                                                 input int unsigned max_pend,
                                                 input int unsigned guard);
    int unsigned span;
    span = per_int * max_pend;
    return (span > guard + 1) ? span - guard : 1;
  endfunction

  // saturating debt update
  function automatic int unsigned credit_next(input int unsigned cur,
                                              input bit due, input bit take,
                                              input int unsigned cap);
    int unsigned n;
    n = cur;
    if (due && !take) n = (cur >= cap) ? cap : cur + 1;
    else if (take && !due) n = cur - 1;
    return n;
  endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int unsigned TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic due
);
  localparam int unsigned TW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic [TW-1:0] phase_q;

  assign due = tick && !restart && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (restart)  phase_q <= '0;
    else if (due)      phase_q <= '0;
    else if (tick)     phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/refsched_credit.sv
module refsched_credit #(
  parameter int unsigned MAX_PEND = 8,
  localparam int unsigned PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          due,
  input  logic          take,
  input  logic          clear,
  output logic [PW-1:0] pend
);
  import refsched_pkg::*;

  logic [PW-1:0] pend_d;

  always_comb begin
    if (clear) pend_d = '0;
    else       pend_d = PW'(credit_next(32'(pend), due, take, MAX_PEND));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_d;
  end
endmodule

// File: rtl/refsched_deadline.sv
module refsched_deadline #(
  parameter int unsigned LIMIT = 76
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic late
);
  localparam int unsigned EW = $clog2(LIMIT + 1);
  localparam logic [EW-1:0] LIM = EW'(LIMIT);

  logic [EW-1:0] age_q;

  assign late = (age_q >= LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 age_q <= '0;
    else if (restart)           age_q <= '0;
    else if (tick && !late)     age_q <= age_q + 1'b1;
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter longint unsigned TICK_PERIOD_PS = 4000,
  parameter longint unsigned INTERVAL_PS    = 15_625_000,
  parameter int unsigned     MAX_PEND       = 8,
  parameter int unsigned     GUARD_TICKS    = 64,
  localparam int unsigned    PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ctl_busy,
  input  logic          ref_grant,
  input  logic          sr_clear,
  output logic          ref_req,
  output logic          ref_urgent,
  output logic [PW-1:0] pend_cnt
);
  import refsched_pkg::*;

  localparam int unsigned PER_INT  = interval_ticks(INTERVAL_PS, TICK_PERIOD_PS);
  localparam int unsigned DEADLINE = deadline_ticks(PER_INT, MAX_PEND, GUARD_TICKS);

  // named internal events
  logic ev_due;
  logic ev_take;
  logic ev_late;
  logic ev_full;
  logic ev_owed;
  logic ev_restart_age;

  assign ev_owed        = (pend_cnt != '0);
  assign ev_full        = (pend_cnt == PW'(MAX_PEND));
  assign ev_take        = ref_grant && ev_owed && !sr_clear;
  assign ev_restart_age = sr_clear || ev_take;

  refsched_timer #(.TICKS(PER_INT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(sr_clear), .due(ev_due)
  );

  refsched_credit #(.MAX_PEND(MAX_PEND)) u_credit (
    .clk(clk), .rst_n(rst_n), .due(ev_due), .take(ev_take),
    .clear(sr_clear), .pend(pend_cnt)
  );

  refsched_deadline #(.LIMIT(DEADLINE)) u_deadline (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(ev_restart_age), .late(ev_late)
  );

  assign ref_urgent = ev_full || (ev_owed && ev_late);
  assign ref_req    = ev_owed && (!ctl_busy || ref_urgent);
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned MAX_PEND = 8,
  parameter int unsigned PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          ctl_busy,
  input logic          sr_clear,
  input logic          ref_req,
  input logic          ref_urgent,
  input logic [PW-1:0] pend_cnt,
  input logic          ev_due,
  input logic          ev_take
);
  AST_PEND_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(MAX_PEND)); // R3
  AST_REQ_NEEDS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> pend_cnt != '0); // R4
  AST_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_busy && pend_cnt != '0) |-> ref_req); // R4
  AST_FULL_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == PW'(MAX_PEND)) |-> (ref_urgent && ref_req)); // R5
  AST_TAKE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && !ev_due) |=> pend_cnt == $past(pend_cnt) - 1'b1); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sr_clear |=> pend_cnt == '0); // R7
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ev_take && !sr_clear) |=> $stable(pend_cnt)); // R9
  AST_DUE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_due |-> tick); // R9
endmodule

bind refresh_sched refresh_sched_chk #(.MAX_PEND(MAX_PEND), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_busy(ctl_busy), .sr_clear(sr_clear),
  .ref_req(ref_req), .ref_urgent(ref_urgent), .pend_cnt(pend_cnt),
  .ev_due(ev_due), .ev_take(ev_take)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  localparam longint unsigned TPS = 4000;
  localparam longint unsigned IPS = 40000;
  localparam int T   = 10;          // IPS / TPS
  localparam int MAXP = 8;
  localparam int GRD = 4;
  localparam int DL  = T * MAXP - GRD; // 76

  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0, ctl_busy = 0, ref_grant = 0, sr_clear = 0;
  logic ref_req, ref_urgent;
  logic [3:0] pend_cnt;

  int total = 0, bad = 0;
  bit cmp_en = 0;

  // reference state
  int m_ph = 0, m_pd = 0, m_age = 0;

  always #2 clk = ~clk;

  refresh_sched #(.TICK_PERIOD_PS(TPS), .INTERVAL_PS(IPS), .MAX_PEND(MAXP),
                  .GUARD_TICKS(GRD)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_busy(ctl_busy),
    .ref_grant(ref_grant), .sr_clear(sr_clear), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .pend_cnt(pend_cnt));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_urg();
    return (m_pd == MAXP) || (m_pd > 0 && m_age >= DL);
  endfunction
  function automatic int exp_req();
    return (m_pd > 0) && (!ctl_busy || exp_urg());
  endfunction

  // arithmetic model, advanced on each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_pd <= 0; m_age <= 0;
    end else if (sr_clear) begin
      m_ph <= 0; m_pd <= 0; m_age <= 0;
    end else begin
      int due, acc, np;
      due = (tick && m_ph == T - 1);
      acc = (ref_grant && m_pd > 0);
      m_ph <= tick ? (m_ph + 1) % T : m_ph;
      np = m_pd + due - acc;
      m_pd <= (np > MAXP) ? MAXP : np;
      m_age <= acc ? 0 : ((tick && m_age < DL) ? m_age + 1 : m_age);
    end
  end

  always @(negedge clk) if (cmp_en && rst_n) begin
    check("R2 pend_cnt", pend_cnt, m_pd);
    check("R4 ref_req", ref_req, exp_req());
    check("R6 ref_urgent", ref_urgent, exp_urg());
  end

  task automatic drive(input logic t, input logic b, input logic g, input logic c);
    @(posedge clk); #1;
    tick = t; ctl_busy = b; ref_grant = g; sr_clear = c;
  endtask

  task automatic do_reset();
    cmp_en = 0;
    @(posedge clk); #1;
    rst_n = 0; tick = 1; ctl_busy = 1; ref_grant = 0; sr_clear = 0;
    @(negedge clk);
    check("R1 pend", pend_cnt, 0);
    check("R1 req", ref_req, 0);
    check("R1 urgent", ref_urgent, 0);
    rst_n = 1;
    cmp_en = 1;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    do_reset();
    // R10: first owed refresh after exactly T ticks
    repeat (T - 1) @(posedge clk);
    @(negedge clk); check("R10 before", pend_cnt, 0);
    @(posedge clk);
    @(negedge clk); check("R10 at", pend_cnt, 1);
    // R6 / R5 / R3: stay busy, never grant
    repeat (DL - T - 1) @(posedge clk);
    @(negedge clk); check("R6 before", ref_urgent, 0); check("R6 pend7", pend_cnt, 7);
    @(posedge clk);
    @(negedge clk); check("R6 late", ref_urgent, 1); check("R6 req busy", ref_req, 1);
    repeat (200) @(posedge clk);
    @(negedge clk); check("R3 sat", pend_cnt, MAXP); check("R5 urgent", ref_urgent, 1);
    check("R5 req", ref_req, 1);
    // R2: burst payback while busy
    for (int k = 0; k < 3; k++) drive(0, 1, 1, 0);
    drive(0, 1, 0, 0);
    @(negedge clk); check("R2 burst", pend_cnt, MAXP - 3);
    // R9: tick low holds
    repeat (40) drive(0, 0, 0, 0);
    @(negedge clk); check("R9 hold", pend_cnt, MAXP - 3);
    // R7: clear
    drive(1, 0, 1, 1);
    drive(1, 0, 0, 0);
    @(negedge clk); check("R7 clear", pend_cnt, 0); check("R7 req", ref_req, 0);
    // R8: grant with nothing owed
    for (int k = 0; k < 5; k++) drive(1, 1, 1, 0);
    drive(1, 1, 0, 0);
    @(negedge clk); check("R8 ignore", pend_cnt, 0);
    // pseudo-random sweep against the model
    do_reset();
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[0] | lf[1], lf[2] & lf[3], (lf[4] & lf[5] & lf[6]) | (ref_urgent & lf[7]),
            (lf[15:8] == 8'h5A));
    end
    drive(0, 0, 0, 0);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule